// File: doc/BRIEF.md
# Split-resolution PWM audio timer

This block turns a stream of PCM samples into one pulse-width-modulated pin. After a low-pass filter on the board, that pin can drive a speaker as a single mono channel, with no separate DAC. Each 16-bit duty word is divided into an upper coarse field and a lower fine field. The coarse field sets the high time of a PWM period that lasts 2^coarse-bits clocks. The fine field adds one clock of high time to a chosen subset of the periods in a frame of 2^fine-bits periods. The average level over a frame therefore resolves all 16 bits, while the carrier runs at the faster coarse rate.

Samples arrive on a valid/ready port, either 16 bits wide or 8 bits wide. The block takes a new word only while it is stopped or on the last clock of a frame. It strobes a request line one cycle after each word it takes. Two compare values are matched against the position within the frame, and each match raises its own one-cycle event flag. A two-bit split field chooses how the word is divided. That field is frozen while the timer runs.

Top module: `split_pwm_timer`

## Requirements
- R1: While reset is held, and on the first clocks after it releases, `pwm_o`, `s_req_o` and both hit flags are low, and `s_ready_o` is high.
- R2: While the timer is stopped, the following hold one clock after `run_i` is sampled low: `pwm_o` is low, the frame position returns to zero, and `s_ready_o` is high.
- R3: The split field sets the widths. Value 0 gives 10 coarse and 6 fine bits, value 1 gives 9 and 7, and values 2 and 3 both give 8 and 8. The coarse part is the upper bits of the duty word and the fine part is the lower bits. One period lasts 2^coarse-bits clocks, and period 0 begins on the clock after `run_i` is first sampled high.
- R4: In period k of a frame, `pwm_o` is high for the first h clocks of the period. Here h = coarse + 1 when the fine-width bit reversal of k is less than fine, and h = coarse otherwise. A coarse value of all ones with the extra clock holds the pin high for the whole period.
- R5: When `s_wide_i` is 1 the duty word is `s_data_i[15:0]`. When it is 0 the duty word is `{s_data_i[7:0], 8'h00}`.
- R6: A word is taken only when `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high while stopped and on the last clock of a frame, and low at all other times while running. A word taken at a frame's end applies from the next frame.
- R7: `s_req_o` is high for exactly the one clock that follows each cycle in which a word was taken.
- R8: If no word is taken at a frame end, the next frame repeats the previous duty word.
- R9: The split field is sampled only while stopped. A change on `mode_i` while running has no effect on the period length or on the duty split.
- R10: A hit flag is high for one clock in the cycle after the frame position equals its compare value. The frame position is period index × 2^coarse-bits + count within the period. Neither flag rises while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = timer running, 0 = stopped |
| mode_i | input | 2 | Coarse/fine split select |
| cmp_a_i | input | 16 | Compare value for flag A |
| cmp_b_i | input | 16 | Compare value for flag B |
| s_valid_i | input | 1 | Sample word offered |
| s_wide_i | input | 1 | 1 = 16-bit sample, 0 = 8-bit sample |
| s_data_i | input | 16 | Sample data |
| s_ready_o | output | 1 | Block can take a word this cycle |
| s_req_o | output | 1 | One-clock strobe after a word is taken |
| pwm_o | output | 1 | PWM audio output |
| cmp_a_hit_o | output | 1 | Compare A event |
| cmp_b_hit_o | output | 1 | Compare B event |

## Verification
The properties assume that `s_valid_i`, `s_wide_i` and `s_data_i` are stable across each rising clock edge. They also assume that `run_i` is driven as a plain level, so a stop or start seen at one edge is the condition for the next cycle. The stimulus changes every input only on the falling edge. It keeps `s_valid_i` low while reset is asserted. It changes `mode_i` in the middle of a run only to show that the change is ignored.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int NCMP = 2;

  typedef enum logic [1:0] {
    SPLIT_10_6  = 2'd0,
    SPLIT_9_7   = 2'd1,
    SPLIT_8_8   = 2'd2,
    SPLIT_8_8_X = 2'd3
  } split_e;
endpackage

// File: rtl/spwm_frame_ctr.sv
// Coarse period counter and period index within a frame.
module spwm_frame_ctr #(
  parameter int DUTY_W   = 16,
  parameter int FINE_MIN = 6,
  localparam int CW = DUTY_W - FINE_MIN,
  localparam int FW = FINE_MIN + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              active,
  input  logic [1:0]        sel,
  output logic [CW-1:0]     cnt,
  output logic [FW-1:0]     idx,
  output logic              frame_end,
  output logic [DUTY_W-1:0] pos
);
  logic [CW-1:0] cmax, cnt_n;
  logic [FW-1:0] fmax, idx_n;
  logic          last_cnt, ce;

  always_comb begin
    cmax      = {CW{1'b1}} >> sel;
    fmax      = {FW{1'b1}} >> (2'd2 - sel);
    last_cnt  = (cnt == cmax);
    frame_end = active & last_cnt & (idx == fmax);
    pos       = (DUTY_W'(idx) << (CW - int'(sel))) | DUTY_W'(cnt);
    ce        = !run | active;
    cnt_n     = cnt;
    idx_n     = idx;
    if (!run) begin
      cnt_n = '0;
      idx_n = '0;
    end else if (last_cnt) begin
      cnt_n = '0;
      idx_n = (idx == fmax) ? '0 : idx + 1'b1;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
    end else if (ce) begin
      cnt <= cnt_n;
      idx <= idx_n;
    end
  end
endmodule

// File: rtl/spwm_dither.sv
// Pulse level from coarse duty plus bit-reversed fine spreading.
module spwm_dither #(
  parameter int DUTY_W   = 16,
  parameter int FINE_MIN = 6,
  localparam int CW = DUTY_W - FINE_MIN,
  localparam int FW = FINE_MIN + 2
) (
  input  logic [DUTY_W-1:0] duty,
  input  logic [1:0]        sel,
  input  logic [CW-1:0]     cnt,
  input  logic [FW-1:0]     idx,
  output logic              level
);
  logic [FW-1:0]     rev_full, rev;
  logic [DUTY_W-1:0] coarse, fine;
  logic [CW:0]       high_len;
  logic              stretch;

  for (genvar b = 0; b < FW; b++) begin : g_rev
    assign rev_full[b] = idx[FW-1-b];
  end

  always_comb begin
    rev      = rev_full >> (2'd2 - sel);
    coarse   = duty >> (FINE_MIN + int'(sel));
    fine     = duty & ~({DUTY_W{1'b1}} << (FINE_MIN + int'(sel)));
    stretch  = {{(DUTY_W-FW){1'b0}}, rev} < fine;
    high_len = coarse[CW:0] + {{CW{1'b0}}, stretch};
    level    = {1'b0, cnt} < high_len;
  end
endmodule

// File: rtl/spwm_sample_reg.sv
// Duty word holding register and take strobe.
module spwm_sample_reg #(
  parameter int DUTY_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              wide,
  input  logic [DUTY_W-1:0] data,
  output logic [DUTY_W-1:0] duty,
  output logic              req
);
  logic [DUTY_W-1:0] duty_n;

  always_comb begin
    duty_n = wide ? data : {data[NARROW_W-1:0], {(DUTY_W-NARROW_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty <= '0;
      req  <= 1'b0;
    end else begin
      req <= take;
      if (take) duty <= duty_n;
    end
  end
endmodule

// File: rtl/split_pwm_timer.sv
module split_pwm_timer #(
  parameter int DUTY_W   = 16,
  parameter int FINE_MIN = 6,
  parameter int NARROW_W = 8,
  localparam int CW = DUTY_W - FINE_MIN,
  localparam int FW = FINE_MIN + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [1:0]        mode_i,
  input  logic [DUTY_W-1:0] cmp_a_i,
  input  logic [DUTY_W-1:0] cmp_b_i,
  input  logic              s_valid_i,
  input  logic              s_wide_i,
  input  logic [DUTY_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              s_req_o,
  output logic              pwm_o,
  output logic              cmp_a_hit_o,
  output logic              cmp_b_hit_o
);
  import spwm_pkg::*;

  logic [1:0]        rst_pipe;
  logic              rst_q_n;
  logic              active;
  split_e            mode_q;
  logic [1:0]        sel;
  logic [CW-1:0]     cnt;
  logic [FW-1:0]     idx;
  logic              frame_end, level, take;
  logic [DUTY_W-1:0] pos, duty;
  logic [DUTY_W-1:0] cmp_val [NCMP];
  logic [NCMP-1:0]   hit_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      active <= 1'b0;
      mode_q <= SPLIT_10_6;
    end else begin
      active <= run_i;
      if (!active) mode_q <= split_e'(mode_i);
    end
  end

  always_comb begin
    sel       = (mode_q == SPLIT_8_8_X) ? 2'd2 : mode_q;
    s_ready_o = !active | frame_end;
    take      = s_valid_i & s_ready_o;
    pwm_o     = active & level;
  end

  spwm_frame_ctr #(.DUTY_W(DUTY_W), .FINE_MIN(FINE_MIN)) u_ctr (
    .clk(clk), .rst_n(rst_q_n), .run(run_i), .active(active), .sel(sel),
    .cnt(cnt), .idx(idx), .frame_end(frame_end), .pos(pos)
  );

  spwm_dither #(.DUTY_W(DUTY_W), .FINE_MIN(FINE_MIN)) u_dith (
    .duty(duty), .sel(sel), .cnt(cnt), .idx(idx), .level(level)
  );

  spwm_sample_reg #(.DUTY_W(DUTY_W), .NARROW_W(NARROW_W)) u_smp (
    .clk(clk), .rst_n(rst_q_n), .take(take), .wide(s_wide_i),
    .data(s_data_i), .duty(duty), .req(s_req_o)
  );

  assign cmp_val[0] = cmp_a_i;
  assign cmp_val[1] = cmp_b_i;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic hit_r;
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) hit_r <= 1'b0;
      else          hit_r <= active & (pos == cmp_val[i]);
    end
    assign hit_q[i] = hit_r;
  end

  assign cmp_a_hit_o = hit_q[0];
  assign cmp_b_hit_o = hit_q[1];
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker (
  input logic       clk,
  input logic       rst_q_n,
  input logic       run_i,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic       s_req_o,
  input logic       pwm_o,
  input logic       cmp_a_hit_o,
  input logic       cmp_b_hit_o,
  input logic       active,
  input logic [1:0] mode_q
);
  assert_req_after_take_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (s_valid_i && s_ready_o) |=> s_req_o);

  assert_req_needs_take_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    s_req_o |-> $past(s_valid_i && s_ready_o));

  assert_stopped_pwm_low_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !run_i |=> !pwm_o);

  assert_stopped_ready_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !run_i |=> s_ready_o);

  assert_hit_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmp_a_hit_o || cmp_b_hit_o) |-> $past(active));

  assert_split_frozen_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    active |=> $stable(mode_q));
endmodule

bind split_pwm_timer spwm_checker u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .run_i(run_i), .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o), .s_req_o(s_req_o), .pwm_o(pwm_o),
  .cmp_a_hit_o(cmp_a_hit_o), .cmp_b_hit_o(cmp_b_hit_o),
  .active(active), .mode_q(mode_q)
);

// File: tb/split_pwm_timer_test.sv
`timescale 1ns/1ps
module split_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] cmp_a_i = 16'd0, cmp_b_i = 16'd0;
  logic        s_valid_i = 1'b0, s_wide_i = 1'b1;
  logic [15:0] s_data_i = 16'd0;
  logic        s_ready_o, s_req_o, pwm_o, cmp_a_hit_o, cmp_b_hit_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct { int high; int k; string tag; } exp_t;
  exp_t exp_q[$];
  int   per_len = 1024;
  bit   mon_arm = 1'b0;

  always #5 clk = ~clk;

  split_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_i(mode_i),
    .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .s_valid_i(s_valid_i),
    .s_wide_i(s_wide_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .s_req_o(s_req_o), .pwm_o(pwm_o), .cmp_a_hit_o(cmp_a_hit_o),
    .cmp_b_hit_o(cmp_b_hit_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic int fine_w(input int m);
    return (m >= 2) ? 8 : 6 + m;
  endfunction

  function automatic int exp_high(input int duty, input int m, input int k);
    int fw = fine_w(m);
    int r = 0;
    int kk = k % (1 << fw);
    for (int b = 0; b < fw; b++) r |= ((kk >> b) & 1) << (fw - 1 - b);
    return (duty >> fw) + ((r < (duty & ((1 << fw) - 1))) ? 1 : 0);
  endfunction

  // driver side: queue the expected high time of each period
  task automatic push_periods(input int duty, input int m, input int k0, input int n, input string tag);
    for (int k = k0; k < k0 + n; k++) exp_q.push_back('{exp_high(duty, m, k), k, tag});
  endtask

  // monitor: count high clocks per period and compare with the queue head
  initial begin
    int acc = 0, n = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_arm && exp_q.size() > 0) begin
        acc += int'(pwm_o);
        n++;
        if (n == per_len) begin
          e = exp_q.pop_front();
          check(acc == e.high, $sformatf("%s period %0d high clocks", e.tag, e.k), acc, e.high);
          acc = 0;
          n = 0;
        end
      end
    end
  end

  task automatic load_stopped(input logic [15:0] d, input bit wide);
    @(negedge clk);
    check(s_ready_o == 1'b1, "R2 ready while stopped", s_ready_o, 1);
    s_valid_i = 1'b1; s_data_i = d; s_wide_i = wide;
    @(negedge clk);
    check(s_req_o == 1'b1, "R7 req after take", s_req_o, 1);
    s_valid_i = 1'b0;
    @(negedge clk);
    check(s_req_o == 1'b0, "R7 req one clock", s_req_o, 0);
  endtask

  task automatic start(input int m);
    mode_i = 2'(m);
    per_len = 1 << (16 - fine_w(m));
    @(negedge clk);
    run_i = 1'b1;
    #1 mon_arm = 1'b1;
  endtask

  task automatic finish_run();
    wait (exp_q.size() == 0);
    @(negedge clk);
    run_i = 1'b0;
    mon_arm = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R2 pwm low after stop", pwm_o, 0);
    check(s_ready_o == 1'b1, "R2 ready after stop", s_ready_o, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hit_a_err, hit_b_err, waited;
    repeat (3) @(negedge clk);
    check(pwm_o == 0 && s_req_o == 0, "R1 outputs low in reset", pwm_o + s_req_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_o == 0 && s_req_o == 0 && cmp_a_hit_o == 0 && cmp_b_hit_o == 0,
          "R1 outputs low after reset", pwm_o + s_req_o + cmp_a_hit_o + cmp_b_hit_o, 0);
    check(s_ready_o == 1'b1, "R1 ready after reset", s_ready_o, 1);

    // R3 R4: 10+6 split, 16-bit word; R9: split change mid-run ignored
    load_stopped(16'h1234, 1'b1);
    push_periods(16'h1234, 0, 0, 8, "R4 split10_6 R9");
    start(0);
    @(negedge clk);
    mode_i = 2'd2;
    check(s_ready_o == 1'b0, "R6 not ready mid-frame", s_ready_o, 0);
    finish_run();

    // R4: full-scale word keeps the pin high in the stretched periods
    load_stopped(16'hFFFF, 1'b1);
    push_periods(16'hFFFF, 0, 0, 8, "R4 full scale");
    start(0);
    finish_run();

    // R5 R3: 8-bit word in 9+7 split; R10 compare flags
    cmp_a_i = 16'd5; cmp_b_i = 16'd600;
    load_stopped(16'h0080, 1'b0);
    push_periods(16'h8000, 1, 0, 4, "R5 narrow split9_7");
    start(1);
    hit_a_err = 0; hit_b_err = 0;
    for (int n = 0; n < 2048; n++) begin
      @(negedge clk);
      if (cmp_a_hit_o != (n == 6))   hit_a_err++;
      if (cmp_b_hit_o != (n == 601)) hit_b_err++;
    end
    check(hit_a_err == 0, "R10 flag A timing", hit_a_err, 0);
    check(hit_b_err == 0, "R10 flag B timing", hit_b_err, 0);
    finish_run();
    cmp_a_i = 16'd0; cmp_b_i = 16'd0;

    // R4: zero duty; R5: narrow word in 8+8 split
    load_stopped(16'hFF00, 1'b0);
    push_periods(16'h0000, 2, 0, 2, "R4 zero duty R5");
    start(2);
    finish_run();

    // R8 R6 R3: split value 3, whole frames, repeat and boundary load
    load_stopped(16'h4003, 1'b1);
    push_periods(16'h4003, 3, 0, 256, "R3 split3 frame1");
    push_periods(16'h4003, 3, 0, 256, "R8 repeat frame2");
    push_periods(16'h10FF, 3, 0, 4, "R6 boundary load frame3");
    start(3);
    repeat (65536 + 100) @(negedge clk);
    s_valid_i = 1'b1; s_data_i = 16'h10FF; s_wide_i = 1'b1;
    waited = 0;
    while (s_req_o !== 1'b1 && waited < 70000) begin
      @(negedge clk);
      waited++;
    end
    check(s_req_o == 1'b1, "R6 take at frame end", s_req_o, 1);
    check(exp_q.size() == 4, "R6 take only at frame end", exp_q.size(), 4);
    s_valid_i = 1'b0;
    @(negedge clk);
    check(s_req_o == 1'b0, "R7 single strobe", s_req_o, 0);
    finish_run();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule